// File: doc/BRIEF.md
# Four-Modulus Decimal Swallow Divider

This block is the programmable feedback divider of an integer-N synthesizer. It divides a fast input clock by a total ratio of 100·H + 10·T + U. The ratio is set as three digits: a hundreds count H, a tens digit T and a units digit U. Inside, a prescaler divides the input clock by one of four moduli: 100, 101, 110 or 111. Three down-counters advance once per prescaler period. The tens and units counters are the swallow counters: each one adds its own increment (10 or 1) to the modulus for as long as it is nonzero. The hundreds counter marks the end of each division cycle.

When the hundreds counter steps to zero, the block emits a pulse one clock wide and reloads all three counters from the digit inputs. The digits are therefore taken only at that reload, so the ratio can be changed at any time without shortening or stretching a cycle that is already running. A combinational flag reports whether the digits on the inputs form a legal setting. If a reload finds an illegal setting, the divider stops and tries the inputs again on every clock. It restarts on the first clock where the setting is legal.

Top module: `quad_mod_divider`

## Requirements
- R1: With a legal setting loaded, successive output pulses are exactly 100·H + 10·T + U input clocks apart. This holds both for T ≤ U and for T > U, and for ratios from 100 up to 100·(2^HUND_W−1)+99.
- R2: The output pulse is high for exactly one input clock per division cycle.
- R3: The valid flag is low whenever T or U, each a 4-bit binary value, exceeds 9.
- R4: The valid flag is low whenever H is zero, H < T or H < U. It is high for every setting that breaks neither R3 nor this rule.
- R5: The digit inputs are sampled only at a reload. A change made in the middle of a cycle takes effect from the next cycle and leaves the current cycle's length unchanged.
- R6: If the setting is illegal at a reload, no further pulses occur while it stays illegal. The divider loads on the first clock edge at which the setting is legal, and the first pulse follows that edge by the full ratio.
- R7: Reset is synchronous and active low, and the pulse output is low while reset is held. The first clock edge with reset released loads the digits. The first pulse follows that edge by the full ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Synchronous reset, active low |
| hund_i | input | HUND_W | Hundreds count H |
| tens_i | input | 4 | Tens digit T |
| unit_i | input | 4 | Units digit U |
| div_pulse_o | output | 1 | One-clock pulse at the end of each division cycle |
| ratio_ok_o | output | 1 | High when the digit inputs form a legal setting |

## Verification
The assertions check the legality flag against the digit inputs on every cycle. They also check that the pulse is never two clocks wide, that the pulse stays low out of reset, and that neither swallow counter ever holds more than the hundreds counter, which is the ordering that makes the moduli add up to the decimal ratio. The spacing between pulses, the deferred use of changed digits, and stopping and restarting around illegal settings are all properties of whole division cycles. Only the bench's scenarios show them, with a clock-by-clock countdown model run over ratios of each swallow ordering.

// File: rtl/qmd_pkg.sv
// Package qmd_pkg
// Shared constants and the prescaler modulus encoding for the decimal
// four-modulus divider. Assumes decimal digits held in 4-bit fields.
package qmd_pkg;

    localparam int unsigned DIGIT_W   = 4;
    localparam int unsigned DIGIT_MAX = 9;
    localparam int unsigned PRE_BASE  = 100;
    localparam int unsigned PRE_TENS  = 10;
    localparam int unsigned PRE_UNIT  = 1;
    localparam int unsigned PRE_MAX   = PRE_BASE + PRE_TENS + PRE_UNIT;
    localparam int unsigned PCNT_W    = $clog2(PRE_MAX);

    // Modulus choice: bit 1 = tens swallow active, bit 0 = units swallow active.
    typedef enum logic [1:0] {
        MOD_BASE = 2'b00,
        MOD_UNIT = 2'b01,
        MOD_TENS = 2'b10,
        MOD_BOTH = 2'b11
    } pre_mod_e;

    // Terminal count (modulus minus one) for a modulus choice.
    function automatic logic [PCNT_W-1:0] mod_last(input pre_mod_e sel);
        int unsigned m;
        m = PRE_BASE;
        if (sel[1]) m = m + PRE_TENS;
        if (sel[0]) m = m + PRE_UNIT;
        return PCNT_W'(m - 1);
    endfunction

endpackage

// File: rtl/qmd_ratio_check.sv
// Module qmd_ratio_check
// Decides whether the three digit inputs form a legal ratio. Legal means
// both lower digits are decimal and the hundreds count is nonzero and
// no smaller than either of them. Purely combinational.
module qmd_ratio_check
    import qmd_pkg::*;
#(
    parameter int unsigned HUND_W = 5
) (
    input  logic [HUND_W-1:0]  hund,
    input  logic [DIGIT_W-1:0] tens,
    input  logic [DIGIT_W-1:0] unit,
    output logic               ok
);

    localparam int unsigned CMP_W = (HUND_W > DIGIT_W) ? HUND_W : DIGIT_W;

    logic [CMP_W-1:0] h_ext, t_ext, u_ext;

    // Widen all three digits to one width and apply the legality rules.
    always_comb begin
        h_ext = CMP_W'(hund);
        t_ext = CMP_W'(tens);
        u_ext = CMP_W'(unit);
        ok = (tens <= DIGIT_W'(DIGIT_MAX)) && (unit <= DIGIT_W'(DIGIT_MAX))
          && (h_ext != '0) && (h_ext >= t_ext) && (h_ext >= u_ext);
    end

endmodule

// File: rtl/qmd_down_cnt.sv
// Module qmd_down_cnt
// Loadable down-counter that saturates at zero. It steps once per
// prescaler tick. A load takes priority over a step. It reports whether it
// is nonzero so that it can act as a swallow control.
module qmd_down_cnt #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] cnt,
    output logic         nz
);

    // Hold, reload or decrement the count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (step && (cnt != '0))
            cnt <= cnt - 1'b1;
    end

    // Flag that the count has not yet reached zero.
    always_comb nz = (cnt != '0);

endmodule

// File: rtl/qmd_prescaler.sv
// Module qmd_prescaler
// Four-modulus prescaler. It counts input clocks and ticks on the last
// clock of each period. Its period is 100, 101, 110 or 111, set by the
// swallow flags. Assumes the modulus choice is stable within a period.
module qmd_prescaler
    import qmd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     restart,
    input  logic     run,
    input  pre_mod_e mod_sel,
    output logic     tick
);

    logic [PCNT_W-1:0] pcnt;

    // Tick when the count reaches the terminal value of the chosen modulus.
    always_comb tick = run && (pcnt == mod_last(mod_sel));

    // Advance the period count, wrapping on a tick or a restart.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pcnt <= '0;
        else if (restart || tick)
            pcnt <= '0;
        else if (run)
            pcnt <= pcnt + 1'b1;
    end

endmodule

// File: rtl/quad_mod_divider.sv
// Module quad_mod_divider
// Decimal integer-N feedback divider: ratio = 100*H + 10*T + U. The tens
// and units swallow counters choose the prescaler modulus, and the
// hundreds counter closes each cycle. Digits are sampled only at a reload.
// Assumes one clock domain.
module quad_mod_divider
    import qmd_pkg::*;
#(
    parameter int unsigned HUND_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [HUND_W-1:0]   hund_i,
    input  logic [DIGIT_W-1:0]  tens_i,
    input  logic [DIGIT_W-1:0]  unit_i,
    output logic                div_pulse_o,
    output logic                ratio_ok_o
);

    localparam int unsigned N_SWALLOW = 2;   // lane 0 = units, lane 1 = tens

    logic                              cfg_ok;
    logic                              run_q;
    logic                              tick;
    logic                              end_cyc;
    logic                              reload;
    logic                              load;
    logic                              pulse_q;
    logic [HUND_W-1:0]                 hund_cnt;
    logic                              hund_nz;
    logic [N_SWALLOW-1:0][DIGIT_W-1:0] sw_in;
    logic [N_SWALLOW-1:0][DIGIT_W-1:0] sw_cnt;
    logic [N_SWALLOW-1:0]              sw_nz;
    pre_mod_e                          mod_sel;

    qmd_ratio_check #(.HUND_W(HUND_W)) u_check (
        .hund (hund_i),
        .tens (tens_i),
        .unit (unit_i),
        .ok   (cfg_ok)
    );

    // Cycle end, reload and load decisions (R1, R6).
    always_comb begin
        end_cyc = tick && (hund_cnt == HUND_W'(1));
        reload  = !run_q || end_cyc;
        load    = reload && cfg_ok;
        sw_in   = {tens_i, unit_i};
        mod_sel = pre_mod_e'(sw_nz);
    end

    // Running state: set by a legal reload, cleared by an illegal one (R6, R7).
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= 1'b0;
        else if (reload)
            run_q <= cfg_ok;
    end

    // Output pulse register: one clock after the last clock of a cycle (R2).
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse_q <= 1'b0;
        else
            pulse_q <= end_cyc;
    end

    qmd_down_cnt #(.W(HUND_W)) u_hund (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (hund_i),
        .step     (tick),
        .cnt      (hund_cnt),
        .nz       (hund_nz)
    );

    generate
        for (genvar g = 0; g < N_SWALLOW; g++) begin : g_swallow
            qmd_down_cnt #(.W(DIGIT_W)) u_sw (
                .clk      (clk),
                .rst_n    (rst_n),
                .load     (load),
                .load_val (sw_in[g]),
                .step     (tick),
                .cnt      (sw_cnt[g]),
                .nz       (sw_nz[g])
            );
        end
    endgenerate

    qmd_prescaler u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load),
        .run     (run_q),
        .mod_sel (mod_sel),
        .tick    (tick)
    );

    // Drive the ports.
    always_comb begin
        div_pulse_o = pulse_q;
        ratio_ok_o  = cfg_ok;
    end

endmodule

// File: rtl/qmd_checker.sv
// Module qmd_checker
// Property checks for quad_mod_divider, attached with bind. Observes the
// ports and the three counter values.
module qmd_checker #(
    parameter int unsigned HUND_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [HUND_W-1:0] hund_i,
    input logic [3:0]        tens_i,
    input logic [3:0]        unit_i,
    input logic              div_pulse_o,
    input logic              ratio_ok_o,
    input logic [HUND_W-1:0] hund_cnt,
    input logic [3:0]        tens_cnt,
    input logic [3:0]        unit_cnt
);

    localparam int unsigned CW = (HUND_W > 4) ? HUND_W : 4;

    // R2
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse_o |=> !div_pulse_o);

    // R3
    digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((tens_i > 4'd9) || (unit_i > 4'd9)) |-> !ratio_ok_o);

    // R4
    digit_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((CW'(hund_i) < CW'(tens_i)) || (CW'(hund_i) < CW'(unit_i)) || (hund_i == '0))
        |-> !ratio_ok_o);

    // R7
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !div_pulse_o);

    // R1
    swallow_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (CW'(tens_cnt) <= CW'(hund_cnt)) && (CW'(unit_cnt) <= CW'(hund_cnt)));

endmodule

bind quad_mod_divider qmd_checker #(.HUND_W(HUND_W)) u_qmd_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hund_i      (hund_i),
    .tens_i      (tens_i),
    .unit_i      (unit_i),
    .div_pulse_o (div_pulse_o),
    .ratio_ok_o  (ratio_ok_o),
    .hund_cnt    (hund_cnt),
    .tens_cnt    (sw_cnt[1]),
    .unit_cnt    (sw_cnt[0])
);

// File: tb/quad_mod_divider_test.sv
// Bench for quad_mod_divider. A behavioural countdown model predicts the
// pulse and the valid flag, and both are compared on every clock.
module quad_mod_divider_test;

    localparam int CLK_PERIOD = 10;
    localparam int HW         = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [HW-1:0] hund = '0;
    logic [3:0]    tens = '0;
    logic [3:0]    unit = '0;
    logic          div_pulse;
    logic          ratio_ok;

    int    total = 0;
    int    bad   = 0;
    string cur_req = "R7";

    // Reference model state.
    bit m_run   = 0;
    int m_left  = 0;
    bit m_pulse = 0;

    quad_mod_divider #(.HUND_W(HW)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .hund_i      (hund),
        .tens_i      (tens),
        .unit_i      (unit),
        .div_pulse_o (div_pulse),
        .ratio_ok_o  (ratio_ok)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit legal(int h, int t, int u);
        return (t <= 9) && (u <= 9) && (h != 0) && (h >= t) && (h >= u);
    endfunction

    // Countdown model: a cycle of 100H+10T+U clocks, loaded only at reload.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_pulse = 0; m_left = 0;
        end else begin
            m_pulse = m_run && (m_left == 1);
            if (!m_run || m_left == 1) begin
                if (legal(hund, tens, unit)) begin
                    m_run = 1; m_left = 100*int'(hund) + 10*int'(tens) + int'(unit);
                end else m_run = 0;
            end else m_left = m_left - 1;
        end
    end

    // Compare both outputs away from the active edge.
    always @(negedge clk) begin
        total++;
        if (div_pulse !== m_pulse) begin
            bad++;
            $display("FAIL %s pulse: actual=%b expected=%b at %0t", cur_req, div_pulse, m_pulse, $time);
        end
        total++;
        if (ratio_ok !== legal(hund, tens, unit)) begin
            bad++;
            $display("FAIL %s ratio_ok (R3 R4): actual=%b expected=%b h=%0d t=%0d u=%0d",
                     cur_req, ratio_ok, legal(hund, tens, unit), hund, tens, unit);
        end
    end

    task automatic set_digits(int h, int t, int u);
        @(posedge clk); #1;
        hund = HW'(h); tens = 4'(t); unit = 4'(u);
    endtask

    task automatic run_clocks(int n);
        repeat (n) @(posedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R7: reset held with a legal setting; no pulse, first load on release.
        cur_req = "R7";
        hund = HW'(10); tens = 4'd2; unit = 4'd3;
        run_clocks(6);
        #1 rst_n = 1'b1;
        // R1 R2: ratio 1023, units swallow outlasts tens.
        cur_req = "R1 R2";
        run_clocks(3 * 1023 + 20);
        // R1: tens outlasts units (T > U), ratio 972.
        set_digits(9, 7, 2);   run_clocks(3 * 1023);
        // R1: maximum digits at H = 9, ratio 999.
        set_digits(9, 9, 9);   run_clocks(3 * 999 + 20);
        // R1: smallest ratio 100.
        set_digits(1, 0, 0);   run_clocks(1200);
        // R1: largest ratio with HUND_W = 5, 3199.
        set_digits(31, 9, 9);  run_clocks(2 * 3199 + 100);
        // R5: digits changed mid-cycle take effect only at the next reload.
        cur_req = "R5";
        set_digits(12, 4, 8);  run_clocks(500);
        set_digits(5, 5, 0);   run_clocks(3 * 1300);
        // R3: tens digit above 9 makes the setting illegal; divider stops.
        cur_req = "R3 R6";
        set_digits(20, 12, 1); run_clocks(3000);
        set_digits(20, 3, 15); run_clocks(200);
        // R4: hundreds below a lower digit, and hundreds zero.
        cur_req = "R4 R6";
        set_digits(3, 5, 1);   run_clocks(300);
        set_digits(4, 2, 7);   run_clocks(300);
        set_digits(0, 0, 0);   run_clocks(300);
        // R6: legal again; load at once and pulse after the full ratio.
        cur_req = "R6";
        set_digits(6, 6, 6);   run_clocks(3 * 666 + 20);
        // R7: reset mid-cycle, then restart.
        cur_req = "R7";
        @(posedge clk); #1 rst_n = 1'b0;
        run_clocks(4);
        #1 rst_n = 1'b1;
        run_clocks(2 * 666 + 20);
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule